// File: doc/BRIEF.md
# Test Access Port Instruction and Data Register Path

This block is the serial test-port front end of a chip. It follows the mode-select line on each rising edge of the test clock through the sixteen-state test controller. It keeps a four-bit instruction register and decodes its contents. It routes one data register at a time between the serial input and the serial output: a one-bit bypass stage, a 32-bit identification register that can also capture a user-programmed code, or an external boundary-scan chain. The test clock may run at a rate unrelated to any system clock.

The boundary cells are not part of the block. It drives select and capture/shift/update strobes to the boundary chain and takes the chain's serial return. It also raises mode outputs that tell the pad logic to drive pins from the boundary register, to float every output, or to run the core from test data. The serial output changes on the falling test-clock edge. It comes with an enable that is high only while a register is shifting.

Top module: `tap_ir_dr_path`

## Requirements
- R1: The controller moves between its sixteen states on each rising `tck` edge as `tms` directs, including both pause loops. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: `trst_n` low forces Test-Logic-Reset at once, without waiting for a clock edge. Every clock spent in Test-Logic-Reset sets the instruction to identify (binary 0010), or to bypass when `HAS_ID` is 0.
- R3: In Capture-IR the instruction shift stage loads binary 0001, so the two lowest bits are 01 and the upper bits are zero. In Shift-IR it shifts toward bit 0, with `tdi` entering bit 3. The active instruction changes only on the edge that leaves Update-IR.
- R4: The instruction codes are: 0000 external test, 0001 sample/preload, 0010 identify, 0011 user code, 0100 internal test, 0101 clamp, 0110 high-impedance, 1111 bypass. Any other code behaves as bypass.
- R5: When bypass is selected, the single bypass stage loads 0 in Capture-DR. In Shift-DR it delays `tdi` by one clock before `tdo`.
- R6: The identify instruction loads the word {version[3:0], part[15:0], maker[10:0], 1'b1} in Capture-DR, MSB to LSB. Shift-DR sends it out LSB first.
- R7: The user-code instruction loads `user_code` into the identification register in Capture-DR. It is shifted out LSB first.
- R8: Sample/preload, external test and internal test raise `bsr_sel` and pass `bsr_so` to `tdo` in Shift-DR. Under those instructions `bsr_capture`, `bsr_shift` and `bsr_update` are high exactly in Capture-DR, Shift-DR and Update-DR.
- R9: `pins_from_bsr` is high for external test, internal test and clamp. `pins_hiz` is high only for high-impedance, and `core_test` only for internal test. Clamp and high-impedance use the bypass stage as their data path.
- R10: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| user_code | input | 32 | User-programmed code loaded by the user-code instruction |
| bsr_so | input | 1 | Serial return from the boundary chain |
| tdo | output | 1 | Serial data out, valid while `tdo_en` is high |
| tdo_en | output | 1 | Output enable for the `tdo` pad |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| pins_from_bsr | output | 1 | Pads take their values from the boundary register |
| pins_hiz | output | 1 | All outputs are placed in high impedance |
| core_test | output | 1 | Core logic is driven from the boundary register |

## Verification
The assertions take `tms`, `tdi` and `bsr_so` to be stable around the rising edge. They also take any release of `trst_n` to fall well away from that edge, so the controller never sees a half-applied reset. The bench changes every input only a few nanoseconds after a falling edge. It releases `trst_n` in the middle of the low phase. It holds `bsr_so` constant from that change until after the next falling edge, where `tdo` samples it.

// File: rtl/tapp_pkg.sv
package tapp_pkg;
    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDENT  = 4'b0010;
    localparam logic [IR_W-1:0] OP_USER   = 4'b0011;
    localparam logic [IR_W-1:0] OP_INTEST = 4'b0100;
    localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0101;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0110;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

    typedef struct packed {
        logic use_byp;
        logic use_id;
        logic use_user;
        logic use_bsr;
        logic drive;
        logic hiz;
        logic core;
    } tap_dec_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tapp_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);
    typedef struct packed {
        tap_state_e state;
    } fsm_t;

    fsm_t r_d;
    tap_state_e st_q;

    always_comb begin
        r_d.state = st_q;
        unique case (st_q)
            ST_RESET:  r_d.state = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   r_d.state = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: r_d.state = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r_d.state = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r_d.state = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r_d.state = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r_d.state = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r_d.state = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r_d.state = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: r_d.state = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: r_d.state = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r_d.state = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r_d.state = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r_d.state = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r_d.state = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: r_d.state = tms ? ST_SEL_DR : ST_IDLE;
            default:   r_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= ST_RESET;
        else         st_q <= r_d.state;
    end

    assign state_q = st_q;

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (st_q == ST_RESET)) else $error("five tms highs"); // R1
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tapp_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state_q,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);
    localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDENT : OP_BYPASS;

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] op;
    } ir_t;

    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (state_q)
            ST_RESET:  r_d.op = RESET_OP;
            ST_CAP_IR: r_d.sh = IR_CAPTURE;
            ST_SH_IR:  r_d.sh = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: r_d.op = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sh <= IR_CAPTURE;
            r_q.op <= RESET_OP;
        end else begin
            r_q <= r_d;
        end
    end

    assign ir_q  = r_q.op;
    assign ir_so = r_q.sh[0];

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_IR) |=> (r_q.sh == IR_CAPTURE)) else $error("ir capture"); // R3
    AST_IR_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ST_UPD_IR && state_q != ST_RESET) |=> $stable(r_q.op)) else $error("ir hold"); // R3
endmodule

// File: rtl/tap_decode.sv
module tap_decode
    import tapp_pkg::*;
#(
    parameter bit HAS_ID = 1'b1
) (
    input  logic [IR_W-1:0] ir_q,
    output tap_dec_t        dec
);
    always_comb begin
        dec = '0;
        unique case (ir_q)
            OP_EXTEST: begin dec.use_bsr = 1'b1; dec.drive = 1'b1; end
            OP_SAMPLE: dec.use_bsr = 1'b1;
            OP_INTEST: begin dec.use_bsr = 1'b1; dec.drive = 1'b1; dec.core = 1'b1; end
            OP_CLAMP:  begin dec.use_byp = 1'b1; dec.drive = 1'b1; end
            OP_HIGHZ:  begin dec.use_byp = 1'b1; dec.hiz = 1'b1; end
            OP_IDENT:  begin dec.use_id = HAS_ID; dec.use_byp = !HAS_ID; end
            OP_USER:   begin dec.use_user = HAS_ID; dec.use_byp = !HAS_ID; end
            default:   dec.use_byp = 1'b1;
        endcase
    end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tapp_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state_q,
    input  tap_dec_t        dec,
    input  logic            tdi,
    input  logic [ID_W-1:0] user_code,
    output logic            byp_so,
    output logic            id_so
);
    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_t;

    dr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state_q == ST_CAP_DR) begin
            r_d.byp = 1'b0;
            if (dec.use_id)   r_d.id = ID_WORD;
            if (dec.use_user) r_d.id = user_code;
        end else if (state_q == ST_SH_DR) begin
            r_d.byp = tdi;
            if (dec.use_id || dec.use_user) r_d.id = {tdi, r_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.byp <= 1'b0;
            r_q.id  <= ID_WORD;
        end else begin
            r_q <= r_d;
        end
    end

    assign byp_so = r_q.byp;
    assign id_so  = r_q.id[0];

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR) |=> (r_q.byp == 1'b0)) else $error("bypass capture"); // R5
    AST_ID_LSB_ONE: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && dec.use_id) |=> (r_q.id[0] == 1'b1)) else $error("id lsb"); // R6
endmodule

// File: rtl/tap_ir_dr_path.sv
module tap_ir_dr_path
    import tapp_pkg::*;
#(
    parameter bit          HAS_ID  = 1'b1,
    parameter logic [3:0]  ID_VER  = 4'h1,
    parameter logic [15:0] ID_PART = 16'h0001,
    parameter logic [10:0] ID_MFR  = 11'h001
) (
    input  logic        tck,
    input  logic        trst_n,
    input  logic        tms,
    input  logic        tdi,
    input  logic [31:0] user_code,
    input  logic        bsr_so,
    output logic        tdo,
    output logic        tdo_en,
    output logic        bsr_sel,
    output logic        bsr_capture,
    output logic        bsr_shift,
    output logic        bsr_update,
    output logic        pins_from_bsr,
    output logic        pins_hiz,
    output logic        core_test
);
    localparam logic [ID_W-1:0] ID_WORD = {ID_VER, ID_PART, ID_MFR, 1'b1};

    tap_state_e      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, byp_so, id_so, dr_so;
    tap_dec_t        dec;

    tap_fsm i_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q));

    tap_ir #(.HAS_ID(HAS_ID)) i_ir (
        .tck(tck), .trst_n(trst_n), .state_q(state_q), .tdi(tdi),
        .ir_q(ir_q), .ir_so(ir_so));

    tap_decode #(.HAS_ID(HAS_ID)) i_dec (.ir_q(ir_q), .dec(dec));

    tap_dr #(.ID_WORD(ID_WORD)) i_dr (
        .tck(tck), .trst_n(trst_n), .state_q(state_q), .dec(dec), .tdi(tdi),
        .user_code(user_code), .byp_so(byp_so), .id_so(id_so));

    always_comb begin
        if (dec.use_bsr)                    dr_so = bsr_so;
        else if (dec.use_id || dec.use_user) dr_so = id_so;
        else                                dr_so = byp_so;
    end

    typedef struct packed {
        logic dat;
        logic en;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.en  = (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
        o_d.dat = (state_q == ST_SH_IR) ? ir_so : dr_so;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) o_q <= '0;
        else         o_q <= o_d;
    end

    assign tdo           = o_q.dat;
    assign tdo_en        = o_q.en;
    assign bsr_sel       = dec.use_bsr;
    assign bsr_capture   = dec.use_bsr && (state_q == ST_CAP_DR);
    assign bsr_shift     = dec.use_bsr && (state_q == ST_SH_DR);
    assign bsr_update    = dec.use_bsr && (state_q == ST_UPD_DR);
    assign pins_from_bsr = dec.drive;
    assign pins_hiz      = dec.hiz;
    assign core_test     = dec.core;

    AST_TDO_EN_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == ST_SH_IR || state_q == ST_SH_DR)) else $error("tdo_en"); // R10
    AST_PIN_MODES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({pins_from_bsr, pins_hiz})) else $error("pin modes"); // R9
    AST_CORE_NEEDS_DRIVE: assert property (@(posedge tck) disable iff (!trst_n)
        core_test |-> (pins_from_bsr && bsr_sel)) else $error("core test"); // R9
endmodule

// File: tb/test_tap_ir_dr_path.sv
module test_tap_ir_dr_path;
    localparam logic [3:0]  VER  = 4'hA;
    localparam logic [15:0] PART = 16'h5C3E;
    localparam logic [10:0] MFR  = 11'h2B5;
    localparam logic [31:0] IDW  = {VER, PART, MFR, 1'b1};
    localparam logic [31:0] UCODE = 32'h1234_ABCD;

    // bench-side state numbering
    localparam int RST = 0, IDL = 1, SDR = 2, CDR = 3, HDR = 4, X1D = 5, PDR = 6, X2D = 7,
                   UDR = 8, SIR = 9, CIR = 10, HIR = 11, X1I = 12, PIR = 13, X2I = 14, UIR = 15;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
    logic [31:0] user_code = UCODE;
    logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update;
    logic pins_from_bsr, pins_hiz, core_test;

    always #10 tck = ~tck;

    tap_ir_dr_path #(.HAS_ID(1'b1), .ID_VER(VER), .ID_PART(PART), .ID_MFR(MFR)) i_tap_ir_dr_path (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .user_code(user_code),
        .bsr_so(bsr_so), .tdo(tdo), .tdo_en(tdo_en), .bsr_sel(bsr_sel),
        .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
        .pins_from_bsr(pins_from_bsr), .pins_hiz(pins_hiz), .core_test(core_test));

    int n_chk = 0, n_bad = 0;
    string cur_req = "R1";
    int st = RST;
    logic [3:0] ins = 4'b0010;
    bit irq[$];
    bit drq[$];
    bit dr_bsr = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    function automatic int nxt(int s, bit m);
        case (s)
            RST: return m ? RST : IDL;
            IDL: return m ? SDR : IDL;
            SDR: return m ? SIR : CDR;
            CDR: return m ? X1D : HDR;
            HDR: return m ? X1D : HDR;
            X1D: return m ? UDR : PDR;
            PDR: return m ? X2D : PDR;
            X2D: return m ? UDR : HDR;
            UDR: return m ? SDR : IDL;
            SIR: return m ? RST : CIR;
            CIR: return m ? X1I : HIR;
            HIR: return m ? X1I : HIR;
            X1I: return m ? UIR : PIR;
            PIR: return m ? X2I : PIR;
            X2I: return m ? UIR : HIR;
            default: return m ? SDR : IDL;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit is_bsr_op(logic [3:0] c);
        return (c == 4'b0000) || (c == 4'b0001) || (c == 4'b0100);
    endfunction

    task automatic model_edge(bit m, bit d);
        case (st)
            RST: ins = 4'b0010;
            CIR: begin irq = {}; irq.push_back(1); for (int i = 1; i < 4; i++) irq.push_back(0); end
            HIR: begin void'(irq.pop_front()); irq.push_back(d); end
            UIR: ins = {irq[3], irq[2], irq[1], irq[0]};
            CDR: begin
                drq = {};
                dr_bsr = is_bsr_op(ins);
                if (ins == 4'b0010)      for (int i = 0; i < 32; i++) drq.push_back(IDW[i]);
                else if (ins == 4'b0011) for (int i = 0; i < 32; i++) drq.push_back(UCODE[i]);
                else                     drq.push_back(0);
            end
            HDR: if (!dr_bsr) begin void'(drq.pop_front()); drq.push_back(d); end
            default: ;
        endcase
        st = nxt(st, m);
    endtask

    task automatic check_outputs();
        bit sel = is_bsr_op(ins);
        chk("R10", "tdo_en", tdo_en, (st == HIR || st == HDR));
        if (st == HIR) chk(cur_req, "tdo in shift-ir", tdo, irq[0]);
        if (st == HDR) chk(cur_req, "tdo in shift-dr", tdo, dr_bsr ? bsr_so : drq[0]);
        chk("R8", "bsr_sel", bsr_sel, sel);
        chk("R8", "bsr strobes", {bsr_capture, bsr_shift, bsr_update},
            {sel && st == CDR, sel && st == HDR, sel && st == UDR});
        chk("R9", "pins_from_bsr", pins_from_bsr, sel && ins != 4'b0001 || ins == 4'b0101);
        chk("R9", "pins_hiz", pins_hiz, ins == 4'b0110);
        chk("R9", "core_test", core_test, ins == 4'b0100);
    endtask

    task automatic step(bit m, bit d);
        logic pre, pre_en;
        tms = m; tdi = d;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bsr_so = lfsr[0];
        pre = tdo; pre_en = tdo_en;
        @(posedge tck); #1;
        if (pre_en) chk("R10", "tdo held across rising edge", tdo, pre);
        model_edge(m, d);
        @(negedge tck); #5;
        check_outputs();
    endtask

    task automatic ir_scan(logic [3:0] c);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(i == 3, c[i]);
        step(1, 0); step(0, 0);
    endtask

    task automatic dr_scan(int n, logic [63:0] v);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, v[i]);
        step(1, 0); step(0, 0);
    endtask

    task automatic do_trst();
        trst_n = 1'b0; #2;
        st = RST; ins = 4'b0010;
        chk("R2", "tdo_en under trst", tdo_en, 0);
        chk("R2", "modes under trst", {bsr_sel, pins_from_bsr, pins_hiz, core_test}, 0);
        @(negedge tck); #5;
        trst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge tck);
        #5;
        cur_req = "R2";
        chk("R2", "reset tdo_en", tdo_en, 0);
        chk("R2", "reset modes", {bsr_sel, bsr_capture, pins_from_bsr, pins_hiz, core_test}, 0);
        trst_n = 1'b1;
        step(1, 0); step(0, 0);
        cur_req = "R6"; dr_scan(32, 64'h0);
        cur_req = "R3"; ir_scan(4'b1111);
        cur_req = "R5"; dr_scan(8, 64'hA5);
        cur_req = "R3"; ir_scan(4'b0011);
        cur_req = "R7"; dr_scan(32, 64'hFFFF_0000);
        cur_req = "R8"; ir_scan(4'b0001); dr_scan(6, 64'h2D);
        ir_scan(4'b0000); dr_scan(4, 64'h9);
        cur_req = "R9"; ir_scan(4'b0100); dr_scan(4, 64'h6);
        ir_scan(4'b0101); dr_scan(4, 64'hB);
        ir_scan(4'b0110); dr_scan(3, 64'h5);
        cur_req = "R4"; ir_scan(4'b1000); dr_scan(5, 64'h13);
        ir_scan(4'b0111); dr_scan(3, 64'h6);
        cur_req = "R1";
        step(1, 0); step(0, 0); step(0, 0); step(0, 1); step(1, 0);
        step(0, 0); step(0, 0); step(1, 0); step(0, 1); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        cur_req = "R2"; dr_scan(32, 64'h0);
        ir_scan(4'b0001);
        step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        do_trst();
        check_outputs();
        step(0, 0);
        dr_scan(32, 64'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule